// File: doc/BRIEF.md
# Translation Lookaside Buffer with Reference and Dirty Tracking

This block is a small, fully associative store of virtual-to-physical page translations that sits between a processor's address path and a page table walker. A lookup presents a virtual page number and an access kind. The VPN is compared against every resident entry in the same cycle. A match with sufficient rights returns the physical page number. A match without sufficient rights raises a protection fault. No match asks the walker for the mapping.

The walker hands back a mapping on the refill port, and the block installs it. Each entry carries a reference bit and a dirty bit that the hardware maintains. A permitted hit sets the reference bit, and a permitted write also sets the dirty bit. Software can zero every reference bit in one pulse, and the refill victim is chosen from those bits. Whenever a valid mapping is displaced, its VPN and dirty bit appear for one cycle, so that the page owner knows whether a write-back is due. A separate pulse drops every mapping at once.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup whose VPN matches a valid entry with the needed right raises `lk_hit` and drives that entry's PPN on `lk_ppn` in the same cycle, with no clock edge in between.
- R2: A lookup that matches no valid entry raises `lk_miss` and holds `lk_ppn` at zero. While `lk_valid` is low, none of `lk_hit`, `lk_miss` or `lk_fault` is raised.
- R3: The access kind uses 0 for read, 1 for write and 2 for execute. These need rights bit 0, bit 1 and bit 2 respectively. A match that lacks its bit raises `lk_fault` alone and changes neither the reference bit nor the dirty bit of the entry.
- R4: A permitted hit sets the entry's reference bit, and a permitted write hit also sets its dirty bit. A newly installed entry starts with both bits clear.
- R5: A refill whose VPN is not resident goes into the lowest-index invalid entry, and no eviction is reported.
- R6: When every entry is valid, the refill replaces the lowest-index entry whose reference bit is clear.
- R7: When every entry is valid and referenced, the refill replaces the entry named by a rotating pointer. The pointer is 0 after reset and advances by one each time it is used.
- R8: Replacing a valid entry raises `evict_valid` for exactly the cycle after the refill edge, with that entry's VPN on `evict_vpn` and its dirty bit on `evict_dirty`.
- R9: A refill whose VPN is already resident rewrites that entry in place, clears its reference and dirty bits, and reports no eviction.
- R10: A `clr_ref` pulse clears every reference bit in one cycle. A permitted hit in the same cycle leaves its own entry's reference bit set.
- R11: An `inv_all` pulse invalidates every entry, and a refill in the same cycle is discarded.
- R12: When a refill and a lookup carry the same VPN in the same cycle, the lookup reports a miss, and the new mapping hits from the next cycle on.
- R13: After reset, no entry is valid and `evict_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No resident mapping; walker request |
| lk_fault | output | 1 | Mapping found but the right is missing |
| lk_ppn | output | 20 | Physical page number on a hit, else zero |
| fill_valid | input | 1 | Refill from the walker |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_rights | input | 3 | Refill rights: bit0 read, bit1 write, bit2 execute |
| clr_ref | input | 1 | Clear all reference bits |
| inv_all | input | 1 | Invalidate all entries |
| evict_valid | output | 1 | A valid mapping was displaced last cycle |
| evict_vpn | output | 20 | VPN of the displaced mapping |
| evict_dirty | output | 1 | Dirty bit of the displaced mapping |

## Verification
Two pairs of functions can land on the same edge. The first pair is a refill and a lookup of the same VPN. The bench drives both in one cycle, expects a miss in that cycle, and expects a hit with the new PPN in the next. The second pair is a reference clear and a permitted hit. The bench fills every entry, marks all of them referenced, and then pulses `clr_ref` together with a read of entry 0. The next refill must evict entry 1 rather than entry 0, which shows through the eviction port that the hit's reference bit survived the clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int RIGHTS_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  // Rights bit 0 = read, 1 = write, 2 = execute; kind 3 is never allowed.
  function automatic logic rights_allow(input logic [RIGHTS_W-1:0] rights,
                                        input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = rights[0];
      ACC_WRITE: ok = rights[1];
      ACC_EXEC:  ok = rights[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tbl,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match_vec,
  output logic                          any_match,
  output logic [IDX_W-1:0]              match_idx
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = valid_vec[e] && (vpn_tbl[e] == key);
  end

  assign any_match = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) match_idx = IDX_W'(e);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               use_rr
);

  logic [IDX_W-1:0] rr_ptr_q;
  logic             all_valid;
  logic             all_ref;

  function automatic logic [IDX_W-1:0] lowest_clear(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!v[e]) idx = IDX_W'(e);
    end
    return idx;
  endfunction

  assign all_valid = &valid_vec;
  assign all_ref   = &ref_vec;
  assign use_rr    = all_valid && all_ref;

  always_comb begin
    if (!all_valid)    victim_idx = lowest_clear(valid_vec);
    else if (!all_ref) victim_idx = lowest_clear(ref_vec);
    else               victim_idx = rr_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr_q <= '0;
    end else if (advance) begin
      rr_ptr_q <= (rr_ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr_q + 1'b1;
    end
  end

  assert_victim_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !all_valid |-> !valid_vec[victim_idx]);

  assert_rr_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (&ref_vec && &valid_vec));

endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int RIGHTS_W = 3,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             inv_all,
  input  logic                             clr_ref,
  input  logic                             fill_we,
  input  logic [IDX_W-1:0]                 fill_idx,
  input  logic [VPN_W-1:0]                 fill_vpn,
  input  logic [PPN_W-1:0]                 fill_ppn,
  input  logic [RIGHTS_W-1:0]              fill_rights,
  input  logic                             touch_we,
  input  logic [IDX_W-1:0]                 touch_idx,
  input  logic                             touch_dirty,
  output logic [ENTRIES-1:0]               valid_vec,
  output logic [ENTRIES-1:0]               ref_vec,
  output logic [ENTRIES-1:0]               dirty_vec,
  output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_tbl,
  output logic [ENTRIES-1:0][PPN_W-1:0]    ppn_tbl,
  output logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_tbl
);

  logic [ENTRIES-1:0]               valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_q;
  logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q;

  // Priority per entry: invalidate, then refill, then hit touch, then clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      ref_q    <= '0;
      dirty_q  <= '0;
      vpn_q    <= '0;
      ppn_q    <= '0;
      rights_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (inv_all) begin
          valid_q[e] <= 1'b0;
          ref_q[e]   <= 1'b0;
          dirty_q[e] <= 1'b0;
        end else if (fill_we && fill_idx == IDX_W'(e)) begin
          valid_q[e]  <= 1'b1;
          ref_q[e]    <= 1'b0;
          dirty_q[e]  <= 1'b0;
          vpn_q[e]    <= fill_vpn;
          ppn_q[e]    <= fill_ppn;
          rights_q[e] <= fill_rights;
        end else if (touch_we && touch_idx == IDX_W'(e)) begin
          ref_q[e] <= 1'b1;
          if (touch_dirty) dirty_q[e] <= 1'b1;
        end else if (clr_ref) begin
          ref_q[e] <= 1'b0;
        end
      end
    end
  end

  assign valid_vec  = valid_q;
  assign ref_vec    = ref_q;
  assign dirty_vec  = dirty_q;
  assign vpn_tbl    = vpn_q;
  assign ppn_tbl    = ppn_q;
  assign rights_tbl = rights_q;

  assert_inv_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));

  assert_clear_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !inv_all) |=> ($countones(ref_q) <= 1));

  assert_touch_sets_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_we && !inv_all && !(fill_we && fill_idx == touch_idx)) |=> ref_q[$past(touch_idx)]);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  localparam int RIGHTS_W = xlat_pkg::RIGHTS_W,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [1:0]          lk_kind,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic                lk_fault,
  output logic [PPN_W-1:0]    lk_ppn,
  input  logic                fill_valid,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [RIGHTS_W-1:0] fill_rights,
  input  logic                clr_ref,
  input  logic                inv_all,
  output logic                evict_valid,
  output logic [VPN_W-1:0]    evict_vpn,
  output logic                evict_dirty
);

  import xlat_pkg::*;

  logic [ENTRIES-1:0]               valid_vec, ref_vec, dirty_vec;
  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_tbl;
  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_tbl;
  logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_tbl;

  logic [ENTRIES-1:0] lk_match_vec, fill_match_vec;
  logic               lk_any, fill_resident;
  logic [IDX_W-1:0]   lk_idx, fill_res_idx, victim_idx, fill_idx;
  logic               use_rr;

  // Named internal events
  logic lk_collide, lk_found, lk_allowed;
  logic touch_we, fill_accept, fill_new, evict_fire, rr_advance;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid_vec (valid_vec),
    .vpn_tbl   (vpn_tbl),
    .key       (lk_vpn),
    .match_vec (lk_match_vec),
    .any_match (lk_any),
    .match_idx (lk_idx)
  );

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .valid_vec (valid_vec),
    .vpn_tbl   (vpn_tbl),
    .key       (fill_vpn),
    .match_vec (fill_match_vec),
    .any_match (fill_resident),
    .match_idx (fill_res_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .ref_vec    (ref_vec),
    .advance    (rr_advance),
    .victim_idx (victim_idx),
    .use_rr     (use_rr)
  );

  // Lookup path
  assign lk_collide = lk_valid && fill_valid && (lk_vpn == fill_vpn);
  assign lk_found   = lk_valid && lk_any && !lk_collide;
  assign lk_allowed = rights_allow(rights_tbl[lk_idx], lk_kind);
  assign lk_hit     = lk_found && lk_allowed;
  assign lk_fault   = lk_found && !lk_allowed;
  assign lk_miss    = lk_valid && !lk_found;
  assign lk_ppn     = lk_hit ? ppn_tbl[lk_idx] : '0;
  assign touch_we   = lk_hit && !inv_all;

  // Refill path
  assign fill_accept = fill_valid && !inv_all;
  assign fill_new    = fill_accept && !fill_resident;
  assign fill_idx    = fill_resident ? fill_res_idx : victim_idx;
  assign evict_fire  = fill_new && valid_vec[victim_idx];
  assign rr_advance  = fill_new && use_rr;

  xlat_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_all     (inv_all),
    .clr_ref     (clr_ref),
    .fill_we     (fill_accept),
    .fill_idx    (fill_idx),
    .fill_vpn    (fill_vpn),
    .fill_ppn    (fill_ppn),
    .fill_rights (fill_rights),
    .touch_we    (touch_we),
    .touch_idx   (lk_idx),
    .touch_dirty (lk_kind == ACC_WRITE),
    .valid_vec   (valid_vec),
    .ref_vec     (ref_vec),
    .dirty_vec   (dirty_vec),
    .vpn_tbl     (vpn_tbl),
    .ppn_tbl     (ppn_tbl),
    .rights_tbl  (rights_tbl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_dirty <= 1'b0;
    end else begin
      evict_valid <= evict_fire;
      evict_vpn   <= evict_fire ? vpn_tbl[victim_idx] : '0;
      evict_dirty <= evict_fire && dirty_vec[victim_idx];
    end
  end

  assert_lookup_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

  assert_collision_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fill_valid && lk_vpn == fill_vpn) |-> (lk_miss && !lk_hit));

  assert_evict_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> ($past(fill_valid) && !$past(inv_all)));

  assert_unique_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec));

endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, fill_valid = 0, clr_ref = 0, inv_all = 0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  lk_kind = '0;
  logic [2:0]  fill_rights = '0;
  logic        lk_hit, lk_miss, lk_fault, evict_valid, evict_dirty;
  logic [19:0] lk_ppn, evict_vpn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rights(fill_rights), .clr_ref(clr_ref), .inv_all(inv_all),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_dirty(evict_dirty)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] E_MISS = 2'd0, E_HIT = 2'd1, E_FAULT = 2'd2;

  typedef struct packed {
    logic        is_fill;
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [2:0]  rights;
    logic [1:0]  kind;
    logic [1:0]  exp;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{1'b1, 20'h00010, 20'h0A010, 3'b011, RD, E_MISS},
    '{1'b1, 20'h00020, 20'h0A020, 3'b001, RD, E_MISS},
    '{1'b1, 20'h00030, 20'h0A030, 3'b100, RD, E_MISS},
    '{1'b0, 20'h00010, 20'h0A010, 3'b000, RD, E_HIT},
    '{1'b0, 20'h00010, 20'h0A010, 3'b000, WR, E_HIT},
    '{1'b0, 20'h00020, 20'h00000, 3'b000, WR, E_FAULT},
    '{1'b0, 20'h00020, 20'h0A020, 3'b000, RD, E_HIT},
    '{1'b0, 20'h00030, 20'h0A030, 3'b000, EX, E_HIT},
    '{1'b0, 20'h00030, 20'h00000, 3'b000, RD, E_FAULT},
    '{1'b0, 20'h00040, 20'h00000, 3'b000, RD, E_MISS},
    '{1'b1, 20'h00010, 20'h0B010, 3'b111, RD, E_MISS},
    '{1'b0, 20'h00010, 20'h0B010, 3'b000, EX, E_HIT}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lv, input logic [19:0] lvpn, input logic [1:0] lk,
                       input logic fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input logic [2:0] fr, input logic clr, input logic inv);
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; lk_kind = lk;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_rights = fr;
    clr_ref = clr; inv_all = inv;
    #2;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check_look(input logic [1:0] exp, input logic [19:0] exp_ppn,
                            input string req);
    logic [2:0] act, want;
    act  = {lk_fault, lk_hit, lk_miss};
    want = (exp == E_HIT) ? 3'b010 : (exp == E_FAULT) ? 3'b100 : 3'b001;
    check(act == want, req, 32'(act), 32'(want));
    check(lk_ppn == exp_ppn, req, 32'(lk_ppn), 32'(exp_ppn));
  endtask

  task automatic check_evict(input logic v, input logic [19:0] vpn, input logic d,
                             input string req);
    check(evict_valid == v, req, 32'(evict_valid), 32'(v));
    if (v) begin
      check(evict_vpn == vpn, req, 32'(evict_vpn), 32'(vpn));
      check(evict_dirty == d, req, 32'(evict_dirty), 32'(d));
    end
  endtask

  task automatic look(input logic [19:0] vpn, input logic [1:0] kind,
                      input logic [1:0] exp, input logic [19:0] ppn, input string req);
    drive(1, vpn, kind, 0, '0, '0, '0, 0, 0);
    check_look(exp, ppn, req);
    tick();
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] r,
                      input logic ev, input logic [19:0] evpn, input logic ed,
                      input string req);
    drive(0, '0, RD, 1, vpn, ppn, r, 0, 0);
    tick();
    check_evict(ev, evpn, ed, req);
  endtask

  task automatic pulse(input logic clr, input logic inv);
    drive(0, '0, RD, 0, '0, '0, '0, clr, inv);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R13: reset state
    drive(1, 20'h00010, RD, 0, '0, '0, '0, 0, 0);
    check_look(E_MISS, '0, "R13 empty after reset");
    check(evict_valid == 0, "R13 evict low", 32'(evict_valid), 0);
    tick();

    // Vector table: R1, R2, R3, R9 basics
    foreach (VECS[i]) begin
      if (VECS[i].is_fill) begin
        fill(VECS[i].vpn, VECS[i].ppn, VECS[i].rights, 0, '0, 0, "R5/R9 fill no evict");
      end else begin
        look(VECS[i].vpn, VECS[i].kind, VECS[i].exp,
             (VECS[i].exp == E_HIT) ? VECS[i].ppn : 20'h0, "R1/R2/R3 table lookup");
      end
    end
    drive(0, 20'h00010, RD, 0, '0, '0, '0, 0, 0);
    check({lk_hit, lk_miss, lk_fault} == 3'b000, "R2 idle quiet",
          32'({lk_hit, lk_miss, lk_fault}), 0);
    tick();

    // Replacement: R4, R5, R6, R7, R8
    pulse(0, 1);
    for (int i = 0; i < 16; i++)
      fill(20'h100 + 20'(i), 20'h200 + 20'(i), 3'b111, 0, '0, 0, "R5 free slot");
    look(20'h103, WR, E_HIT, 20'h203, "R4 write hit");
    look(20'h100, RD, E_HIT, 20'h200, "R4 read hit");
    fill(20'h300, 20'h400, 3'b111, 1, 20'h101, 0, "R6 lowest unreferenced");
    drive(0, '0, RD, 0, '0, '0, '0, 0, 0);
    tick();
    check(evict_valid == 0, "R8 single cycle", 32'(evict_valid), 0);
    look(20'h100, RD, E_HIT, 20'h200, "R4 ref all");
    look(20'h300, RD, E_HIT, 20'h400, "R4 ref all");
    for (int i = 2; i < 16; i++)
      look(20'h100 + 20'(i), RD, E_HIT, 20'h200 + 20'(i), "R4 ref all");
    fill(20'h301, 20'h401, 3'b111, 1, 20'h100, 0, "R7 pointer at 0");
    look(20'h301, RD, E_HIT, 20'h401, "R4 ref new");
    fill(20'h302, 20'h402, 3'b111, 1, 20'h300, 0, "R7 pointer advanced");
    pulse(1, 0);
    look(20'h301, RD, E_HIT, 20'h401, "R10 reref");
    look(20'h302, RD, E_HIT, 20'h402, "R10 reref");
    look(20'h102, RD, E_HIT, 20'h202, "R10 reref");
    for (int i = 4; i < 16; i++)
      look(20'h100 + 20'(i), RD, E_HIT, 20'h200 + 20'(i), "R10 reref");
    fill(20'h303, 20'h403, 3'b111, 1, 20'h103, 1, "R4 dirty on eviction R10 clear");
    fill(20'h102, 20'h999, 3'b111, 0, '0, 0, "R9 resident refill");
    look(20'h102, RD, E_HIT, 20'h999, "R9 new ppn");

    // R10 clear with same-cycle hit; R3 fault leaves status
    pulse(0, 1);
    for (int i = 0; i < 16; i++)
      fill(20'h500 + 20'(i), 20'h600 + 20'(i), (i == 1) ? 3'b001 : 3'b111, 0, '0, 0,
           "R5 refill");
    for (int i = 0; i < 16; i++)
      look(20'h500 + 20'(i), RD, E_HIT, 20'h600 + 20'(i), "R4 ref all");
    drive(1, 20'h500, RD, 0, '0, '0, '0, 1, 0);
    check_look(E_HIT, 20'h600, "R10 hit during clear");
    tick();
    look(20'h501, WR, E_FAULT, 20'h0, "R3 write denied");
    fill(20'h600, 20'h700, 3'b111, 1, 20'h501, 0, "R10 hit survives clear R3 no dirty");

    // R11 invalidate discards same-cycle refill
    drive(0, '0, RD, 1, 20'h700, 20'h800, 3'b111, 0, 1);
    tick();
    look(20'h700, RD, E_MISS, 20'h0, "R11 refill discarded");
    look(20'h600, RD, E_MISS, 20'h0, "R11 invalidated");
    fill(20'h701, 20'h801, 3'b111, 0, '0, 0, "R11 no eviction after invalidate");

    // R12 collision
    drive(1, 20'h800, RD, 1, 20'h800, 20'h888, 3'b111, 0, 0);
    check_look(E_MISS, 20'h0, "R12 same-cycle miss");
    tick();
    look(20'h800, RD, E_HIT, 20'h888, "R12 hit next cycle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule